// File: doc/BRIEF.md
# Segment descriptor decoder and bounds checker

This block takes an eight-byte segment descriptor, presented as a low and a high 32-bit word. It splits the descriptor into its scattered base address, limit, type, descriptor class, privilege level, present, default-size and granularity fields, and puts each field on its own output. The decoded fields are combinational. The granularity bit sets the effective limit: with the bit clear the limit counts single bytes, and with the bit set it counts 4 KiB pages.

A strobe starts a check of one operation against the segment. For a push, the current stack pointer is reduced by the operand size of 2 or 4 bytes, and the reduced pointer is the address that gets checked. For an ordinary access, the supplied offset is the address that gets checked. An expand-down data segment accepts only addresses that lie strictly above its limit. Every other segment accepts only an access whose last byte lies at or below its limit. A selector whose index field is zero is always rejected.

The result is registered. A successful push loads the new pointer into the stack pointer output. A rejected operation leaves that output unchanged and raises the fault flag for exactly one cycle.

Top module: `seg_desc_check`

## Requirements
- R1: The base output is the concatenation high[31:24], high[7:0], low[31:16], with low[31:16] forming base bits 15:0.
- R2: The type output is high[11:8]. The class bit is high[12], the privilege level is high[14:13], present is high[15], default size is high[22] and granularity is high[23].
- R3: The raw limit is {high[19:16], low[15:0]}. The effective limit output equals the raw limit when granularity is 0, and (raw << 12) | 0xFFF when granularity is 1.
- R4: A push that is accepted (strobe with push=1) sets the stack pointer output, one cycle later, to the stack pointer input minus 2 (wide=0) or minus 4 (wide=1). With no strobe, the output holds its value.
- R5: A segment is expand-down when the class bit is 1, type bit 3 is 0 and type bit 2 is 1 (for example type 6). For such a segment, an address at or below the effective limit faults. For example, limit 0x7A00 with pointer 0x7A04 and a 4-byte push faults, and pointer 0x7A05 gives 0x7A01 with no fault.
- R6: For any other segment, an operation faults when address + size - 1 exceeds the effective limit. An operation whose last byte is exactly at the limit is accepted.
- R7: A selector with bits 15:3 equal to zero faults whatever the descriptor is. Bits 2:0 play no part in this test.
- R8: The fault output is 1 only in the cycle after a strobe whose operation is rejected. A rejected operation leaves the stack pointer output unchanged.
- R9: For an expand-down segment, an operation whose last byte lies beyond 0xFFFFFFFF also faults.
- R10: While reset is asserted, the stack pointer output is 0 and the fault output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_lo | input | 32 | Low descriptor word |
| desc_hi | input | 32 | High descriptor word |
| sel | input | 16 | Selector; bits 15:3 are the index |
| sp_in | input | 32 | Current stack pointer |
| offset | input | 32 | Offset used by an ordinary access |
| wide | input | 1 | Operand size: 1 for 4 bytes, 0 for 2 bytes |
| is_push | input | 1 | 1 for a push, 0 for an ordinary access |
| req | input | 1 | Strobe that starts a check |
| seg_base | output | 32 | Decoded base address |
| seg_limit | output | 32 | Effective limit in bytes |
| seg_type | output | 4 | Type field |
| code_data | output | 1 | Descriptor class bit |
| seg_dpl | output | 2 | Descriptor privilege level |
| seg_present | output | 1 | Present bit |
| seg_big | output | 1 | Default operand size bit |
| seg_gran | output | 1 | Granularity bit |
| sp_out | output | 32 | Registered stack pointer |
| fault | output | 1 | One-cycle fault pulse |

## Verification
The hardest cases to reach are the one-byte edges of both limit rules. These are a push that lands exactly on the limit or exactly one byte above it, an access whose last byte sits exactly on a page-scaled limit, and an expand-down access that runs past the top of the address space. The stimulus programs descriptors whose limits sit just beside chosen pointers and offsets, and tries both operand sizes on each side of every edge. After a series of pushes, it then issues a rejected push so that an unchanged pointer can be told apart from a reset value.

// File: rtl/seg_desc_check.sv
module seg_desc_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] desc_lo,
  input  logic [31:0] desc_hi,
  input  logic [15:0] sel,
  input  logic [31:0] sp_in,
  input  logic [31:0] offset,
  input  logic        wide,
  input  logic        is_push,
  input  logic        req,
  output logic [31:0] seg_base,
  output logic [31:0] seg_limit,
  output logic [3:0]  seg_type,
  output logic        code_data,
  output logic [1:0]  seg_dpl,
  output logic        seg_present,
  output logic        seg_big,
  output logic        seg_gran,
  output logic [31:0] sp_out,
  output logic        fault
);
  logic [19:0] raw_lim;
  logic [31:0] size, addr;
  logic [32:0] last;
  logic        null_sel, exp_down, bad;
  logic        sel_unused;

  assign seg_base    = {desc_hi[31:24], desc_hi[7:0], desc_lo[31:16]};
  assign raw_lim     = {desc_hi[19:16], desc_lo[15:0]};
  assign seg_type    = desc_hi[11:8];
  assign code_data   = desc_hi[12];
  assign seg_dpl     = desc_hi[14:13];
  assign seg_present = desc_hi[15];
  assign seg_big     = desc_hi[22];
  assign seg_gran    = desc_hi[23];
  assign seg_limit   = seg_gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};

  assign sel_unused = ^sel[2:0];
  assign null_sel   = (sel[15:3] == 13'd0);
  assign exp_down   = code_data & ~seg_type[3] & seg_type[2];

  assign size = wide ? 32'd4 : 32'd2;
  assign addr = is_push ? sp_in - size : offset;
  assign last = {1'b0, addr} + {1'b0, size} - 33'd1;

  always_comb begin
    if (null_sel)
      bad = 1'b1;
    else if (exp_down)
      bad = (addr <= seg_limit) | last[32];
    else
      bad = (last > {1'b0, seg_limit});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_out <= 32'd0;
      fault  <= 1'b0;
    end else begin
      fault <= req & bad;
      if (req && is_push && !bad)
        sp_out <= addr;
    end
  end
endmodule

module seg_desc_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] sel,
  input logic [31:0] sp_in,
  input logic        wide,
  input logic        is_push,
  input logic        req,
  input logic        seg_gran,
  input logic [31:0] seg_limit,
  input logic [31:0] sp_out,
  input logic        fault
);
  p_fault_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req));

  p_sp_kept_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(sp_out));

  p_sp_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(sp_out));

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && $past(req && is_push)) |->
      sp_out == $past(sp_in) - ($past(wide) ? 32'd4 : 32'd2));

  p_null_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel[15:3] == 13'd0) |=> fault);

  p_page_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_gran |-> seg_limit[11:0] == 12'hFFF);
endmodule

bind seg_desc_check seg_desc_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sp_in(sp_in), .wide(wide),
  .is_push(is_push), .req(req), .seg_gran(seg_gran), .seg_limit(seg_limit),
  .sp_out(sp_out), .fault(fault)
);

// File: tb/seg_desc_check_bench.sv
module seg_desc_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] desc_lo = '0, desc_hi = '0, sp_in = '0, offset = '0;
  logic [15:0] sel = '0;
  logic        wide = 1'b0, is_push = 1'b0, req = 1'b0;
  logic [31:0] seg_base, seg_limit, sp_out;
  logic [3:0]  seg_type;
  logic        code_data, seg_present, seg_big, seg_gran, fault;
  logic [1:0]  seg_dpl;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_desc_check u_seg_desc_check (
    .clk(clk), .rst_n(rst_n), .desc_lo(desc_lo), .desc_hi(desc_hi), .sel(sel),
    .sp_in(sp_in), .offset(offset), .wide(wide), .is_push(is_push), .req(req),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_type(seg_type),
    .code_data(code_data), .seg_dpl(seg_dpl), .seg_present(seg_present),
    .seg_big(seg_big), .seg_gran(seg_gran), .sp_out(sp_out), .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] lo, input logic [31:0] hi, input logic [15:0] s);
    @(negedge clk);
    desc_lo = lo; desc_hi = hi; sel = s;
    #1;
  endtask

  task automatic op(input logic push, input logic w, input logic [31:0] sp, input logic [31:0] off);
    @(negedge clk);
    is_push = push; wide = w; sp_in = sp; offset = off; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 sp_out in reset", sp_out, 32'd0);
    chk("R10 fault in reset", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_decode;
    load(32'h7C0001FF, 32'h00409800, 16'h0008);
    chk("R1 base code", seg_base, 32'h00007C00);
    chk("R3 limit code", seg_limit, 32'h000001FF);
    chk("R2 type code", {28'd0, seg_type}, 32'h8);
    chk("R2 flags code", {26'd0, code_data, seg_dpl, seg_present, seg_big, seg_gran}, 32'b1_00_1_1_0);
    load(32'h8000FFFF, 32'h0040920B, 16'h0010);
    chk("R1 base data", seg_base, 32'h000B8000);
    chk("R3 limit data", seg_limit, 32'h0000FFFF);
    chk("R2 type data", {28'd0, seg_type}, 32'h2);
    load(32'h56780001, 32'h12C0F234, 16'h0010);
    chk("R1 base all bytes", seg_base, 32'h12345678);
    chk("R3 paged limit", seg_limit, 32'h00001FFF);
    chk("R2 flags paged", {26'd0, code_data, seg_dpl, seg_present, seg_big, seg_gran}, 32'b1_11_1_1_1);
  endtask

  task automatic t_stack;
    load(32'h00007A00, 32'h00409600, 16'h0018);
    op(1'b1, 1'b1, 32'h7A04, 32'h0);
    chk("R5 push to 0x7A00 faults", {31'd0, fault}, 32'd1);
    chk("R8 sp unchanged after fault", sp_out, 32'd0);
    @(negedge clk);
    chk("R8 fault lasts one cycle", {31'd0, fault}, 32'd0);
    op(1'b1, 1'b1, 32'h7A05, 32'h0);
    chk("R5 push to 0x7A01 ok", {31'd0, fault}, 32'd0);
    chk("R4 sp after 4-byte push", sp_out, 32'h7A01);
    op(1'b1, 1'b0, 32'h7C00, 32'h0);
    chk("R4 sp after 2-byte push", sp_out, 32'h7BFE);
    repeat (3) @(negedge clk);
    chk("R4 sp holds when idle", sp_out, 32'h7BFE);
    op(1'b1, 1'b0, 32'h7A02, 32'h0);
    chk("R5 2-byte push to limit faults", {31'd0, fault}, 32'd1);
    chk("R8 sp kept after fault", sp_out, 32'h7BFE);
  endtask

  task automatic t_null;
    load(32'h00007A00, 32'h00409600, 16'h0003);
    op(1'b1, 1'b1, 32'h9000, 32'h0);
    chk("R7 null selector rpl3 faults", {31'd0, fault}, 32'd1);
    chk("R7 sp kept on null", sp_out, 32'h7BFE);
    load(32'h00007A00, 32'h00409600, 16'h0004);
    op(1'b1, 1'b1, 32'h9000, 32'h0);
    chk("R7 null selector ti faults", {31'd0, fault}, 32'd1);
    load(32'h00007A00, 32'h00409600, 16'h000B);
    op(1'b1, 1'b1, 32'h9000, 32'h0);
    chk("R7 index 1 accepted", {31'd0, fault}, 32'd0);
    chk("R7 sp after index 1 push", sp_out, 32'h8FFC);
  endtask

  task automatic t_expand_up;
    load(32'h8000FFFF, 32'h0040920B, 16'h0010);
    op(1'b0, 1'b1, 32'h0, 32'hFFFC);
    chk("R6 last byte at limit ok", {31'd0, fault}, 32'd0);
    chk("R4 access leaves sp", sp_out, 32'h8FFC);
    op(1'b0, 1'b1, 32'h0, 32'hFFFD);
    chk("R6 one past limit faults", {31'd0, fault}, 32'd1);
    op(1'b0, 1'b0, 32'h0, 32'hFFFE);
    chk("R6 2-byte at limit ok", {31'd0, fault}, 32'd0);
    load(32'h00000001, 32'h00C09200, 16'h0010);
    op(1'b0, 1'b1, 32'h0, 32'h1FFC);
    chk("R3 paged limit edge ok", {31'd0, fault}, 32'd0);
    op(1'b0, 1'b1, 32'h0, 32'h1FFD);
    chk("R3 paged limit past faults", {31'd0, fault}, 32'd1);
  endtask

  task automatic t_expand_down_access;
    load(32'h00007A00, 32'h00409600, 16'h0018);
    op(1'b0, 1'b0, 32'h0, 32'h7A00);
    chk("R5 access at limit faults", {31'd0, fault}, 32'd1);
    op(1'b0, 1'b0, 32'h0, 32'h7A01);
    chk("R5 access above limit ok", {31'd0, fault}, 32'd0);
    op(1'b0, 1'b1, 32'h0, 32'hFFFFFFFE);
    chk("R9 access past top faults", {31'd0, fault}, 32'd1);
    op(1'b0, 1'b1, 32'h0, 32'hFFFFFFFC);
    chk("R9 access ending at top ok", {31'd0, fault}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_decode;
    t_stack;
    t_null;
    t_expand_up;
    t_expand_down_access;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule